// File: doc/BRIEF.md
# SPI Status-First Register Reader

This block is an SPI slave that works in mode 0 and lets a host read a bank of registers that lives outside the block. At the start of every transaction it sends a status byte while the host is still shifting in its command byte. The host learns the status without a separate request. When the command asks for a read, each later byte the slave sends holds one register. The first is the register the command named, and each one after it is at the next address. N registers therefore cost N+1 byte exchanges.

The bus pins are oversampled by a system clock through two-flop synchronizers. The system clock must run at least eight times faster than the serial clock. The register bank sits outside the block and is read through a plain address/data port. The block drives the address, and the bank returns the data combinationally, or within a few system clocks. Each new transmit byte is taken when the serial clock falls after the last bit of the previous byte.

Top module: `spi_status_reader`

## Requirements
- R1: Bits move in both directions at once, most significant bit first. The slave samples MOSI on the rising SCLK edge and changes MISO after the falling edge (mode 0).
- R2: The first byte the slave sends in every transaction is the status input as sampled when CS_n goes low, whatever the command is.
- R3: In the first host byte, bit 7 = 1 means read, and bits 4:0 give the start address. Bits 6:5 are ignored. After a read command, the second byte out is the register at that address.
- R4: After each data byte is loaded, the address advances by one and wraps from 31 to 0. The next byte out is the register at the new address.
- R5: The values of the dummy bytes the host sends after the command have no effect on the data returned.
- R6: If bit 7 of the first host byte is 0, every later byte of that transaction is 0x00.
- R7: Raising CS_n drops any partial byte. The next transaction again starts with the status byte and treats its first full byte as a command.
- R8: MISO is held at 0 while CS_n is high, including right after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the host, idle low |
| mosi | input | 1 | Serial data from the host |
| cs_n | input | 1 | Active-low select from the host |
| miso | output | 1 | Serial data to the host |
| status | input | 8 | Status value sent as the first byte |
| reg_addr | output | 5 | Register bank read address |
| reg_rdata | input | 8 | Register bank read data for reg_addr |

## Verification
The bench builds the block with its default parameters: a 5-bit address and 8-bit bytes. With 32 registers, a stream that starts at address 30 crosses the wrap from 31 to 0 within four data bytes. A host byte with bits 6:5 set shows that only bits 4:0 select the start address. Other tests use a non-read command, a transfer aborted after three bits, and a status value that changes between transactions. Across these, the status-first rule, the zero fill and the recovery after an abort are each seen on real byte streams.

// File: rtl/spi_status_reader.sv
module spi_status_reader #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              mosi,
  input  logic              cs_n,
  output logic              miso,
  input  logic [DATA_W-1:0] status,
  output logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_rdata
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic [2:0] sclk_s, cs_s;
  logic [1:0] mosi_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_s <= '0;
      cs_s   <= '1;
      mosi_s <= '0;
    end else begin
      sclk_s <= {sclk_s[1:0], sclk};
      cs_s   <= {cs_s[1:0], cs_n};
      mosi_s <= {mosi_s[0], mosi};
    end

  wire cs_q    = cs_s[1];
  wire cs_fall = cs_s[2] & ~cs_s[1];
  wire s_rise  = ~sclk_s[2] & sclk_s[1];
  wire s_fall  = sclk_s[2] & ~sclk_s[1];

  logic [DATA_W-1:0] tx, rx;
  logic [CNT_W-1:0]  bitcnt;
  logic [ADDR_W-1:0] addr;
  logic              first, pending, rd_mode, data_ph;

  wire [DATA_W-1:0] rx_byte = {rx[DATA_W-2:0], mosi_s[1]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx <= '0; rx <= '0; bitcnt <= '0; addr <= '0;
      first <= 1'b1; pending <= 1'b0; rd_mode <= 1'b0; data_ph <= 1'b0;
    end else if (cs_q) begin
      tx <= '0; bitcnt <= '0;
      first <= 1'b1; pending <= 1'b0; rd_mode <= 1'b0; data_ph <= 1'b0;
    end else if (cs_fall) begin
      tx <= status;
    end else if (s_rise) begin
      rx     <= rx_byte;
      bitcnt <= bitcnt + 1'b1;
      if (bitcnt == LAST_BIT) begin
        pending <= 1'b1;
        if (first) begin
          first   <= 1'b0;
          rd_mode <= rx_byte[DATA_W-1];
          addr    <= rx_byte[ADDR_W-1:0];
        end
      end
    end else if (s_fall) begin
      if (pending) begin
        pending <= 1'b0;
        data_ph <= 1'b1;
        tx      <= rd_mode ? reg_rdata : '0;
        if (rd_mode) addr <= addr + 1'b1;
      end else begin
        tx <= {tx[DATA_W-2:0], 1'b0};
      end
    end

  assign miso     = ~cs_q & tx[DATA_W-1];
  assign reg_addr = addr;

  // R2: status MSB appears once select is seen low
  a_r2_status_first: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_q) |=> miso == $past(status[DATA_W-1]));

  // R4: each data load steps the address with wrap
  a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (s_fall && pending && rd_mode && !cs_q && !cs_fall)
      |=> reg_addr == ADDR_W'($past(reg_addr) + 1'b1));

  // R6: a non-read command yields only zero bits in the data phase
  a_r6_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (data_ph && !rd_mode) |-> !miso);

  // R7: deselect returns to command expectation
  a_r7_abort: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_q) |=> (first && bitcnt == '0 && !pending && !data_ph));

  // R8: output quiet while deselected
  a_r8_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_q && $past(cs_q)) |-> !miso);
endmodule

// File: tb/spi_status_reader_test.sv
module spi_status_reader_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, mosi = 1'b0, cs_n = 1'b1;
  logic miso;
  logic [7:0] status = 8'h00;
  logic [4:0] reg_addr;
  logic [7:0] reg_rdata;

  always #10 clk = ~clk;

  function automatic logic [7:0] bank_f(input logic [4:0] a);
    return {a, 3'b101} ^ 8'h3C;
  endfunction

  assign reg_rdata = bank_f(reg_addr);

  spi_status_reader uut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .mosi(mosi), .cs_n(cs_n),
    .miso(miso), .status(status), .reg_addr(reg_addr), .reg_rdata(reg_rdata)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] got_q[$];

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  task automatic expect_byte(input logic [7:0] v, input string tag);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  task automatic xfer(input logic [7:0] tb, output logic [7:0] rb);
    for (int i = 7; i >= 0; i--) begin
      mosi = tb[i];
      repeat (8) @(negedge clk);
      rb[i] = miso;
      sclk = 1'b1;
      repeat (8) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic txn(input logic [7:0] cmd, input int nd, input logic [7:0] seed);
    logic [7:0] r;
    cs_n = 1'b0;
    repeat (8) @(negedge clk);
    xfer(cmd, r);
    got_q.push_back(r);
    for (int i = 0; i < nd; i++) begin
      xfer(seed ^ 8'(i * 37), r);
      got_q.push_back(r);
    end
    repeat (8) @(negedge clk);
    cs_n = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic expect_read(input logic [7:0] st, input logic [4:0] a, input int nd, input string tag);
    expect_byte(st, "R2 status byte");
    for (int i = 0; i < nd; i++) expect_byte(bank_f(5'(a + i)), tag);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      while (got_q.size() > 0 && exp_q.size() > 0)
        check(tag_q.pop_front(), got_q.pop_front(), exp_q.pop_front());
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_up();
  end

  initial begin : driver
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R8 reset miso", {7'd0, miso}, 8'h00);
    check("R8 reset addr", {3'd0, reg_addr}, 8'h00);

    status = 8'h5A;
    expect_read(8'h5A, 5'd3, 4, "R1 R3 R4 R5 stream from 3");
    txn(8'h83, 4, 8'hFF);

    check("R8 idle miso", {7'd0, miso}, 8'h00);

    status = 8'hC3;
    expect_read(8'hC3, 5'd30, 4, "R4 wrap 31 to 0");
    txn(8'h9E, 4, 8'h00);

    status = 8'h81;
    expect_byte(8'h81, "R2 status on write-type command");
    for (int i = 0; i < 3; i++) expect_byte(8'h00, "R6 zero fill");
    txn(8'h05, 3, 8'hA5);

    status = 8'h3F;
    expect_read(8'h3F, 5'd2, 2, "R3 bits 6:5 ignored");
    txn(8'hE2, 2, 8'h5A);

    status = 8'h77;
    expect_read(8'h77, 5'd2, 2, "R5 other dummy pattern");
    txn(8'h82, 2, 8'hC6);

    status = 8'h96;
    cs_n = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      mosi = 1'b1;
      repeat (8) @(negedge clk);
      sclk = 1'b1;
      repeat (8) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (8) @(negedge clk);
    cs_n = 1'b1;
    repeat (10) @(negedge clk);
    check("R8 idle after abort", {7'd0, miso}, 8'h00);
    status = 8'h6C;
    expect_read(8'h6C, 5'd10, 2, "R7 clean start after abort");
    txn(8'h8A, 2, 8'h11);

    repeat (20) @(negedge clk);
    checks++;
    if (exp_q.size() != 0 || got_q.size() != 0) begin
      fails++;
      $display("FAIL R1 byte count actual=%0d expected=0", exp_q.size() + got_q.size());
    end
    finish_up();
  end
endmodule